// File: doc/BRIEF.md
# Configurable six-input lookup logic cell

This block models a 64-bit lookup table of the kind used as the logic element of a programmable fabric. The table is built from four 16-entry quarters. Quarters 3 and 2 form the upper half, addressed from input bus `a`. Quarters 1 and 0 form the lower half, addressed from input bus `b`. Quarter n normally drives output `f[n]`.

Each half runs in one of two modes. In split mode it computes two four-input functions. In wide mode it computes one five-input function. A special-gate field can then combine the two wide results with the side input `c0`. It offers a 2:1 selector or a three-way XOR on `f[1]`, together with an inverted AND on `f[2]`. Feeding the same five signals to both buses and using `c0` as the sixth yields any six-input function on `f[1]`.

The table contents and the mode are loaded through a synchronous write port before use. The outputs are purely combinational from the inputs and the stored configuration.

Top module: `lut6_cell`

## Requirements
- R1: After reset every quarter holds zero and the mode is zero (both halves split, no special gate), so `f` reads 4'b0000 and `err` reads 0 for any inputs.
- R2: When `cfg_we` is high at a rising clock edge, `cfg_data` replaces quarter `cfg_addr` (0 to 3). When `mode_we` is high, `mode_in` replaces the mode. Both take effect from that edge. Without a write, the outputs depend only on `a`, `b` and `c0`.
- R3: Mode bit 1 low puts the upper half in split mode, and mode bit 0 low does the same for the lower half. In split mode the lower quarter of a half (2 or 0) outputs bit {in3,in2,in1,in0} of its table, and the upper quarter (3 or 1) outputs bit {in4,in3,in2,in1}. The two quarters share in1 to in3.
- R4: With mode bit 1 high, `f[3]` is bit `a[4:0]` of the 32-bit value {quarter3, quarter2} and `f[2]` is 0. With mode bit 0 high, `f[0]` is bit `b[4:0]` of {quarter1, quarter0} and `f[1]` is 0. This holds when no special gate applies.
- R5: The two halves choose their modes independently, so split and wide modes can be mixed across the halves.
- R6: Mode bits [3:2] = 01 with both halves wide selects the selector gate. `f[1]` equals `f[3]` when `c0` is 1 and `f[0]` when `c0` is 0, and `f[3]` and `f[0]` keep their wide values.
- R7: Mode bits [3:2] = 10 with both halves wide selects the XOR gate, with `f[1]` = `f[3]` ^ `f[0]` ^ `c0`.
- R8: Whenever the selector or the XOR gate applies, `f[2]` = NOT(`f[3]` AND `f[0]` AND `c0`).
- R9: `err` is 1 when mode bits [3:2] = 11, or when they are nonzero while either half is in split mode. The special field is then ignored, and the outputs follow R3 to R5.
- R10: With both halves wide and the selector gate on, driving `a` = `b` = x[4:0] and `c0` = x[5] makes `f[1]` equal bit x of the 64-bit value {quarter3, quarter2, quarter1, quarter0}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration write port |
| rst_n | input | 1 | Active-low asynchronous reset of table and mode |
| cfg_we | input | 1 | Write enable for one table quarter |
| cfg_addr | input | 2 | Quarter index written |
| cfg_data | input | 16 | New quarter contents, entry 0 in bit 0 |
| mode_we | input | 1 | Write enable for the mode |
| mode_in | input | 4 | Mode: bit0 lower half wide, bit1 upper half wide, [3:2] special gate |
| a | input | 5 | Upper-half input bus |
| b | input | 5 | Lower-half input bus |
| c0 | input | 1 | Side input to the special gates |
| f | output | 4 | Function outputs, f[n] from quarter n |
| err | output | 1 | Illegal mode combination flag |

## Verification
The bench builds the cell with its default quarter input count of four, which gives 16-entry quarters and 5-bit buses. At that size all 64 six-input addresses can be walked exhaustively for R10. Random tables are combined with random input vectors in every legal and illegal mode, so each split index mapping, each wide half, the mixed cases and both special gates are exercised against a model built from the requirements.

// File: rtl/lut6_cell.sv
module lut6_cell #(
  parameter int QIN = 4,
  localparam int QD = 1 << QIN,
  localparam int BW = QIN + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [QD-1:0] cfg_data,
  input  logic          mode_we,
  input  logic [3:0]    mode_in,
  input  logic [BW-1:0] a,
  input  logic [BW-1:0] b,
  input  logic          c0,
  output logic [3:0]    f,
  output logic          err
);
  logic [QD-1:0] q [4];
  logic [3:0]    mode_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) q[i] <= '0;
      mode_r <= '0;
    end else begin
      if (cfg_we) q[cfg_addr] <= cfg_data;
      if (mode_we) mode_r <= mode_in;
    end
  end

  logic          a_wide, b_wide, mux_on, xor_on;
  logic [1:0]    sp;
  logic [2*QD-1:0] half_a, half_b;
  logic          fa_hi, fa_lo, fb_hi, fb_lo;

  assign a_wide = mode_r[1];
  assign b_wide = mode_r[0];
  assign sp     = mode_r[3:2];
  assign half_a = {q[3], q[2]};
  assign half_b = {q[1], q[0]};

  assign fa_hi = a_wide ? half_a[a] : q[3][a[BW-1:1]];
  assign fa_lo = a_wide ? 1'b0      : q[2][a[QIN-1:0]];
  assign fb_hi = b_wide ? 1'b0      : q[1][b[BW-1:1]];
  assign fb_lo = b_wide ? half_b[b] : q[0][b[QIN-1:0]];

  assign mux_on = (sp == 2'd1) && a_wide && b_wide;
  assign xor_on = (sp == 2'd2) && a_wide && b_wide;
  assign err    = (sp == 2'd3) || ((sp != 2'd0) && !(a_wide && b_wide));

  assign f[3] = fa_hi;
  assign f[0] = fb_lo;
  assign f[1] = mux_on ? (c0 ? fa_hi : fb_lo) :
                xor_on ? (fa_hi ^ fb_lo ^ c0) : fb_hi;
  assign f[2] = (mux_on || xor_on) ? ~(fa_hi & fb_lo & c0) : fa_lo;

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && !mode_we) |=> (!$stable({a, b, c0}) || $stable(f)));

  // R6
  mux_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mux_on |-> (f[1] == (c0 ? f[3] : f[0])));

  // R7
  xor_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xor_on |-> (^{f[1], f[3], f[0], c0} == 1'b0));

  // R8
  nand_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mux_on || xor_on) && !f[2]) |-> (f[3] && f[0] && c0));

  // R9
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!(mux_on || xor_on) && (mode_r[3:2] != 2'd0)));
endmodule

// File: tb/lut6_cell_bench.sv
module lut6_cell_bench;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, mode_we = 0, c0 = 0;
  logic [1:0] cfg_addr = 0;
  logic [15:0] cfg_data = 0;
  logic [3:0] mode_in = 0;
  logic [4:0] a = 0, b = 0;
  logic [3:0] f;
  logic err;

  always #2 clk = ~clk;

  lut6_cell u_lut6_cell (.clk, .rst_n, .cfg_we, .cfg_addr, .cfg_data, .mode_we,
    .mode_in, .a, .b, .c0, .f, .err);

  typedef struct { logic [3:0] ef; logic ee; string tag; } item_t;
  item_t sb[$];
  int compared = 0, mismatched = 0;
  bit done = 0;
  logic [15:0] tq [4];
  logic [3:0] tmode = 0;

  task automatic wr_q(input int idx, input logic [15:0] d);
    @(posedge clk); #1; cfg_we = 1; cfg_addr = idx[1:0]; cfg_data = d;
    @(posedge clk); #1; cfg_we = 0;
    tq[idx] = d;
  endtask

  task automatic wr_mode(input logic [3:0] m);
    @(posedge clk); #1; mode_we = 1; mode_in = m;
    @(posedge clk); #1; mode_we = 0;
    tmode = m;
  endtask

  task automatic apply(input logic [4:0] ai, input logic [4:0] bi, input logic ci, input string tag);
    item_t it;
    logic aw, bw, mx, xr;
    logic [31:0] ha, hb;
    logic h3, h2, h1, h0;
    @(posedge clk); #1; a = ai; b = bi; c0 = ci;
    aw = tmode[1]; bw = tmode[0];
    ha = {tq[3], tq[2]}; hb = {tq[1], tq[0]};
    h3 = aw ? ha[ai] : tq[3][ai[4:1]];
    h2 = aw ? 1'b0 : tq[2][ai[3:0]];
    h1 = bw ? 1'b0 : tq[1][bi[4:1]];
    h0 = bw ? hb[bi] : tq[0][bi[3:0]];
    mx = tmode[3:2] == 2'b01 && aw && bw;
    xr = tmode[3:2] == 2'b10 && aw && bw;
    if (mx) h1 = ci ? h3 : h0;
    if (xr) h1 = h3 ^ h0 ^ ci;
    if (mx || xr) h2 = !(h3 && h0 && ci);
    it.ef = {h3, h2, h1, h0};
    it.ee = tmode[3:2] == 2'b11 || (tmode[3:2] != 0 && !(aw && bw));
    it.tag = tag;
    sb.push_back(it);
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      compared++;
      if (f !== it.ef || err !== it.ee) begin
        mismatched++;
        $display("FAIL %s actual f=%b err=%b expected f=%b err=%b", it.tag, f, err, it.ef, it.ee);
      end
    end
  end

  task automatic rand_run(input logic [3:0] m, input string tag);
    for (int k = 0; k < 4; k++) wr_q(k, 16'($urandom));
    wr_mode(m);
    for (int n = 0; n < 40; n++) apply(5'($urandom), 5'($urandom), 1'($urandom), tag);
  endtask

  initial begin
    for (int k = 0; k < 4; k++) tq[k] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    for (int n = 0; n < 6; n++) apply(5'($urandom), 5'($urandom), 1'($urandom), "R1 reset");
    wr_q(2, 16'h0020); wr_q(3, 16'h0004);
    apply(5'b00101, 0, 0, "R2 write q2");
    apply(5'b00100, 0, 0, "R2 write q3");
    apply(5'b01010, 0, 0, "R3 upper quarter index");
    rand_run(4'b0000, "R3 split both");
    rand_run(4'b0011, "R4 wide both");
    rand_run(4'b0010, "R5 mixed A wide");
    rand_run(4'b0001, "R5 mixed B wide");
    rand_run(4'b0111, "R6 mux R8");
    rand_run(4'b1011, "R7 xor R8");
    rand_run(4'b1111, "R9 illegal code");
    rand_run(4'b0101, "R9 mux with split half");
    rand_run(4'b1000, "R9 xor with split halves");
    rand_run(4'b0011, "R4 wide both again");
    for (int k = 0; k < 4; k++) wr_q(k, 16'($urandom));
    wr_mode(4'b0111);
    for (int x = 0; x < 64; x++) begin
      logic [63:0] t6;
      t6 = {tq[3], tq[2], tq[1], tq[0]};
      apply(5'(x), 5'(x), 1'(x >> 5), "R10 six-input");
      if (sb[$].ef[1] !== t6[x]) begin
        mismatched++;
        $display("FAIL R10 model f1=%b expected=%b at x=%0d", sb[$].ef[1], t6[x], x);
      end
    end
    wait (sb.size() == 0);
    @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(4 * 50000);
    if (!done) begin
      mismatched++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule